// File: doc/BRIEF.md
# Shared-Line Delta-Sigma ADC Word Reader

This block sits on the host side of a delta-sigma converter whose conversion-ready flag and serial data share one wire. The wire idles high. It goes low when a fresh result waits. The first rising serial-clock edge turns the wire from a status flag into the data output, and each later rising edge presents the next bit, most significant first. The reader watches the wire through a synchroniser and confirms the low level before it reacts. It then produces a clean, register-driven serial clock, collects a 24-bit two's-complement result and hands it to parallel logic as a word with a one-cycle valid strobe.

A configuration input decides whether a 25th clock pulse follows the data. That pulse makes the converter drive the wire high until the next result, which suits level polling. Without it the reader waits for the converter to release the wire by itself. In both cases the reader re-arms only after it has seen the wire high. An enable input gates the start of new transfers. An acknowledge input lets the host mark a word as consumed, and an overrun flag records a new transfer that started while the previous word was still unacknowledged.

Top module: `adc_word_reader`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `sclk`=0, `word_valid`=0, `overrun`=0 and `word_out`=0. The reader then sits idle.
- R2: A transfer starts only after the synchronised line has been low in two consecutive samples. The line passes through two flops before it is sampled. When the line goes low while the reader waits, the first `sclk` rise appears on the fourth rising `clk` edge after the line first reads low. A low pulse lasting one clock starts nothing.
- R3: With `enable` low, no transfer starts. With `enable` high, a ready indication is accepted only after the line has first been seen high since the reader was armed or since the last transfer.
- R4: `sclk` is low whenever no transfer is in progress. Each high phase and each low phase lasts `div_cfg`+2 clock cycles.
- R5: The line is sampled on the clock edge that ends each low phase, so the first bit is taken after the first pulse. Bits are shifted in MSB first. `word_out` equals the 24 received bits, and bit 23 is the sign.
- R6: `word_valid` is high for exactly one cycle, on the edge that ends the 24th low phase. `word_out` is updated on that edge and holds until the next word.
- R7: With `extra_clk_en`=1, exactly 25 `sclk` pulses are issued per transfer. With `extra_clk_en`=0, exactly 24 are issued. In both cases no new transfer starts until the line has been seen high again.
- R8: `overrun` is set when a transfer starts while a previous word has not been acknowledged. A one-cycle `word_ack` clears both the pending word and `overrun` on the following edge.
- R9: Dropping `enable` during a transfer has no effect on that transfer. All its pulses are issued and its word is delivered, and the reader then goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows new transfers to start |
| extra_clk_en | input | 1 | Issue the 25th pulse that forces the line high |
| div_cfg | input | DIV_W | Serial half period is div_cfg+2 clock cycles |
| word_ack | input | 1 | Host acknowledges the last word |
| rdy_dout | input | 1 | Shared ready/data line from the converter |
| sclk | output | 1 | Serial clock to the converter, registered |
| word_out | output | WORD_W | Last captured conversion word |
| word_valid | output | 1 | One-cycle strobe for a new word |
| overrun | output | 1 | A transfer started before the previous word was acknowledged |

## Verification
Several properties are checked on every cycle: the quiet outputs after reset, the single-cycle valid strobe, the timing of the valid strobe (it always follows a low phase of the serial clock), a low serial clock outside transfers, minimum high and low phase lengths, and the link between overrun and the pending word, including its clearing by acknowledge. Other behaviour can only be shown by scenarios. These cover the exact word content for the extreme two's-complement values, the pulse count in each mode, the rejection of a one-cycle low glitch, the start latency, the refusal to arm on a line that is already low, and a transfer that completes after enable is dropped. A behavioural model in the bench predicts the serial clock, strobe, word and overrun flag on every clock.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int WORD_BITS = 24;
    localparam int DIV_BITS  = 8;
    localparam int MIN_HALF  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_WAIT,
        ST_HIGH,
        ST_LOW,
        ST_XHI,
        ST_XLO
    } rd_state_e;

    typedef struct packed {
        logic pend;
        logic ovr;
    } rd_flags_t;

    function automatic logic is_clocking(rd_state_e s);
        return (s == ST_HIGH) || (s == ST_LOW) || (s == ST_XHI) || (s == ST_XLO);
    endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int STAGES  = 2,
    parameter int LOW_RUN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic line,
    output logic rdy_low
);
    logic [STAGES-1:0]  chain_q;
    logic [LOW_RUN-2:0] low_hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
        end
    end

    assign line = chain_q[STAGES-1];

    generate
        if (LOW_RUN == 2) begin : g_run2
            always_ff @(posedge clk) begin
                if (rst) low_hist_q <= '0;
                else     low_hist_q <= ~line;
            end
        end else begin : g_runn
            always_ff @(posedge clk) begin
                if (rst) low_hist_q <= '0;
                else     low_hist_q <= {low_hist_q[LOW_RUN-3:0], ~line};
            end
        end
    endgenerate

    assign rdy_low = ~line & (&low_hist_q);

endmodule

// File: rtl/adc_rd_half_timer.sv
module adc_rd_half_timer #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             done
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    assign lim  = CW'(div_cfg) + CW'(MIN_HALF - 1);
    assign done = (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] data,
    output logic         last
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
            data  <= '0;
        end else if (shift_en) begin
            data  <= {data[W-2:0], bit_in};
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == CW'(W - 1));

endmodule

// File: rtl/adc_word_reader.sv
module adc_word_reader
    import adc_rd_pkg::*;
#(
    parameter int WORD_W      = WORD_BITS,
    parameter int DIV_W       = DIV_BITS,
    parameter int SYNC_STAGES = 2,
    parameter int LOW_RUN     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              extra_clk_en,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic              word_ack,
    input  logic              rdy_dout,
    output logic              sclk,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              overrun
);
    rd_state_e   st_q, st_n;
    logic        sclk_q, sclk_n;
    logic        line, rdy_low;
    logic        t_done, t_restart;
    logic        cap, start, done_word;
    logic        sh_last;
    logic [WORD_W-1:0] sh_data;
    logic [WORD_W-1:0] word_q;
    logic        valid_q;
    rd_flags_t   flags_q;

    adc_rd_sync #(.STAGES(SYNC_STAGES), .LOW_RUN(LOW_RUN)) u_sync (
        .clk(clk), .rst(rst), .pin(rdy_dout), .line(line), .rdy_low(rdy_low)
    );

    assign t_restart = !is_clocking(st_q) || t_done;

    adc_rd_half_timer #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_timer (
        .clk(clk), .rst(rst), .restart(t_restart), .div_cfg(div_cfg), .done(t_done)
    );

    adc_rd_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .clear(start), .shift_en(cap), .bit_in(line),
        .data(sh_data), .last(sh_last)
    );

    always_comb begin
        st_n      = st_q;
        sclk_n    = sclk_q;
        cap       = 1'b0;
        start     = 1'b0;
        done_word = 1'b0;
        case (st_q)
            ST_IDLE: if (enable) st_n = ST_ARM;
            ST_ARM: begin
                if (!enable)   st_n = ST_IDLE;
                else if (line) st_n = ST_WAIT;
            end
            ST_WAIT: begin
                if (!enable) begin
                    st_n = ST_IDLE;
                end else if (rdy_low) begin
                    st_n   = ST_HIGH;
                    sclk_n = 1'b1;
                    start  = 1'b1;
                end
            end
            ST_HIGH: begin
                if (t_done) begin
                    st_n   = ST_LOW;
                    sclk_n = 1'b0;
                end
            end
            ST_LOW: begin
                if (t_done) begin
                    cap = 1'b1;
                    if (sh_last) begin
                        done_word = 1'b1;
                        if (extra_clk_en) begin
                            st_n   = ST_XHI;
                            sclk_n = 1'b1;
                        end else begin
                            st_n = ST_ARM;
                        end
                    end else begin
                        st_n   = ST_HIGH;
                        sclk_n = 1'b1;
                    end
                end
            end
            ST_XHI: begin
                if (t_done) begin
                    st_n   = ST_XLO;
                    sclk_n = 1'b0;
                end
            end
            ST_XLO: if (t_done) st_n = ST_ARM;
            default: begin
                st_n   = ST_IDLE;
                sclk_n = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            sclk_q  <= 1'b0;
            word_q  <= '0;
            valid_q <= 1'b0;
            flags_q <= '0;
        end else begin
            st_q    <= st_n;
            sclk_q  <= sclk_n;
            valid_q <= done_word;
            if (done_word) word_q <= {sh_data[WORD_W-2:0], line};
            if (word_ack)                   flags_q.ovr <= 1'b0;
            else if (start && flags_q.pend) flags_q.ovr <= 1'b1;
            if (done_word)     flags_q.pend <= 1'b1;
            else if (word_ack) flags_q.pend <= 1'b0;
        end
    end

    assign sclk       = sclk_q;
    assign word_out   = word_q;
    assign word_valid = valid_q;
    assign overrun    = flags_q.ovr;

endmodule

// File: rtl/adc_word_reader_chk.sv
module adc_word_reader_chk
    import adc_rd_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      sclk,
    input logic      word_valid,
    input logic      overrun,
    input logic      word_ack,
    input rd_flags_t flags,
    input rd_state_e st
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sclk && !word_valid && !overrun));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R5
    valid_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> !$past(sclk));

    // R4
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE || st == ST_ARM || st == ST_WAIT) |-> !sclk);

    // R4
    high_min_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> $past(sclk, 2));

    // R4
    low_min_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> !$past(sclk, 2));

    // R8
    ovr_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> flags.pend);

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        word_ack |=> (!overrun && !flags.pend));

endmodule

bind adc_word_reader adc_word_reader_chk u_chk (
    .clk(clk), .rst(rst), .sclk(sclk), .word_valid(word_valid),
    .overrun(overrun), .word_ack(word_ack), .flags(flags_q), .st(st_q)
);

// File: tb/tb_adc_word_reader.sv
module tb_adc_word_reader;
    logic clk = 1'b0;
    logic rst = 1'b1, enable = 1'b0, extra = 1'b0, ack = 1'b0, pin = 1'b1;
    logic [7:0]  div = 8'd0;
    logic        sclk, valid, ovr;
    logic [23:0] word;

    always #2.5 clk = ~clk;

    adc_word_reader dut (
        .clk(clk), .rst(rst), .enable(enable), .extra_clk_en(extra), .div_cfg(div),
        .word_ack(ack), .rdy_dout(pin), .sclk(sclk), .word_out(word),
        .word_valid(valid), .overrun(ovr)
    );

    int checks = 0, fails = 0, cyc = 0;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // input snapshots taken at the edge
    logic s_rst, s_en, s_extra, s_ack, s_pin;
    logic [7:0] s_div;
    always @(posedge clk) begin
        s_rst <= rst; s_en <= enable; s_extra <= extra;
        s_ack <= ack; s_pin <= pin; s_div <= div;
    end

    // reference model state
    int m_st = 0, m_t = 0, m_h = 2, m_np = 25;
    logic [3:0]  hist = 4'hF;
    logic [23:0] m_acc = '0, m_word = '0;
    bit m_sclk = 0, m_valid = 0, m_ovr = 0, m_pend = 0;

    // converter model state
    int a_st = 0, a_k = 0, a_rel = 0, a_low_cyc = 0, lat = -1;
    logic [23:0] a_word = '0;
    bit a_req = 0, a_glitch = 0, a_drop = 0;
    bit sclk_prev = 0, seen_valid = 0;
    int rise_cnt = 0, hi_run = 0, last_hi = 0;

    always @(negedge clk) begin
        bit start, done, rise;
        cyc++;
        start = 0; done = 0;
        if (s_rst) begin
            m_st = 0; hist = 4'hF; m_sclk = 0; m_valid = 0;
            m_ovr = 0; m_pend = 0; m_word = '0;
        end else begin
            hist = {hist[2:0], s_pin};
            m_valid = 0;
            case (m_st)
                0: if (s_en) m_st = 1;
                1: if (!s_en) m_st = 0; else if (hist[2]) m_st = 2;
                2: begin
                    if (!s_en) m_st = 0;
                    else if (!hist[2] && !hist[3]) begin
                        m_st = 3; m_t = 0; m_h = int'(s_div) + 2;
                        m_np = 25; m_sclk = 1; start = 1; m_acc = '0;
                    end
                end
                default: begin
                    m_t++;
                    if (m_t % (2 * m_h) == 0 && m_t / (2 * m_h) <= 24) begin
                        m_acc = {m_acc[22:0], hist[2]};
                        if (m_t == 48 * m_h) begin
                            m_word = m_acc; m_valid = 1; done = 1;
                            m_np = s_extra ? 25 : 24;
                        end
                    end
                    if (m_t >= 2 * m_h * m_np) begin
                        m_st = 1; m_sclk = 0;
                    end else begin
                        m_sclk = (m_t % (2 * m_h)) < m_h;
                    end
                end
            endcase
            if (s_ack) m_ovr = 0; else if (start && m_pend) m_ovr = 1;
            if (done) m_pend = 1; else if (s_ack) m_pend = 0;
        end

        chk(sclk == m_sclk, "R4 sclk", sclk, m_sclk);
        chk(valid == m_valid, "R6 valid", valid, m_valid);
        if (m_valid) chk(word == m_word, "R5 word", word, m_word);
        chk(ovr == m_ovr, "R8 overrun", ovr, m_ovr);
        if (valid) seen_valid = 1;

        rise = sclk && !sclk_prev;
        sclk_prev = sclk;
        if (rise) rise_cnt++;
        if (sclk) hi_run++;
        else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end

        case (a_st)
            0: begin
                if (a_req) begin
                    a_req = 0; pin = 0; a_st = 1; a_low_cyc = cyc; lat = -1;
                end else if (a_glitch) begin
                    a_glitch = 0; pin = 0; a_st = 4;
                end
            end
            1: begin
                if (a_drop) begin
                    a_drop = 0; pin = 1; a_st = 0;
                end else if (rise) begin
                    lat = cyc - a_low_cyc; a_k = 1; a_rel = 0;
                    pin = a_word[23]; a_st = 2;
                end
            end
            2: begin
                if (rise) begin
                    a_k++; a_rel = 0;
                    if (a_k <= 24) pin = a_word[24 - a_k];
                    else begin pin = 1; a_st = 0; end
                end else if (a_k == 24) begin
                    a_rel++;
                    if (a_rel == 2 * (int'(div) + 2) + 6) begin pin = 1; a_st = 0; end
                end
            end
            default: begin pin = 1; a_st = 0; end
        endcase
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_ack();
        ack = 1; tick(1); ack = 0;
    endtask

    task automatic xfer(logic [23:0] w, bit ex, bit do_ack);
        int r0, k;
        extra = ex; a_word = w; r0 = rise_cnt; seen_valid = 0; a_req = 1;
        k = 0;
        while (!seen_valid && k < 20000) begin tick(1); k++; end
        chk(seen_valid, "R6 strobe seen", seen_valid, 1);
        chk(word == w, "R5 word content", word, w);
        tick(3);
        chk(word == w, "R6 word holds", word, w);
        tick(2 * (int'(div) + 2) + 30);
        chk(rise_cnt - r0 == (ex ? 25 : 24), "R7 pulse count", rise_cnt - r0, ex ? 25 : 24);
        chk(pin == 1'b1, "R7 line high after", pin, 1);
        if (do_ack) pulse_ack();
        tick(4);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        int r0;
        tick(4);
        chk(sclk == 0, "R1 sclk", sclk, 0);
        chk(valid == 0, "R1 valid", valid, 0);
        chk(ovr == 0, "R1 overrun", ovr, 0);
        chk(word == 0, "R1 word", word, 0);
        rst = 0;
        tick(5);

        // R3: disabled reader ignores ready, then refuses to arm on a low line
        r0 = rise_cnt; a_req = 1;
        tick(40);
        chk(rise_cnt == r0, "R3 disabled", rise_cnt, r0);
        enable = 1;
        tick(40);
        chk(rise_cnt == r0, "R3 line low at arm", rise_cnt, r0);
        a_drop = 1;
        tick(10);

        // main transfers, both modes, two dividers
        xfer(24'h800000, 1, 1);
        chk(lat == 4, "R2 start latency", lat, 4);
        xfer(24'h7FFFFF, 0, 1);
        div = 8'd3;
        tick(2);
        xfer(24'hA5C3E1, 1, 1);
        chk(last_hi == 5, "R4 half period", last_hi, 5);
        xfer(24'h000001, 0, 1);
        div = 8'd0;
        tick(2);

        // R2: one-cycle glitch starts nothing
        r0 = rise_cnt; a_glitch = 1;
        tick(30);
        chk(rise_cnt == r0, "R2 glitch", rise_cnt, r0);

        // R8: second word without acknowledge
        xfer(24'h123456, 1, 0);
        chk(ovr == 0, "R8 no overrun yet", ovr, 0);
        xfer(24'hFEDCBA, 1, 0);
        chk(ovr == 1, "R8 overrun set", ovr, 1);
        pulse_ack();
        tick(1);
        chk(ovr == 0, "R8 ack clears", ovr, 0);

        // R9: enable dropped mid-transfer
        extra = 1; a_word = 24'h5A5A5A; r0 = rise_cnt; seen_valid = 0; a_req = 1;
        begin
            int k = 0;
            while (rise_cnt < r0 + 5 && k < 5000) begin tick(1); k++; end
        end
        enable = 0;
        begin
            int k = 0;
            while (!seen_valid && k < 5000) begin tick(1); k++; end
        end
        chk(word == 24'h5A5A5A, "R9 word delivered", word, 24'h5A5A5A);
        tick(40);
        chk(rise_cnt - r0 == 25, "R9 all pulses", rise_cnt - r0, 25);
        pulse_ack();
        r0 = rise_cnt; a_req = 1;
        tick(40);
        chk(rise_cnt == r0, "R9 idle after", rise_cnt, r0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule